// File: doc/BRIEF.md
# Shared-Unit Two-Expression Datapath

This block evaluates a pair of related arithmetic results from five unsigned operands: X is W plus the product S·T, and Y is the sum of the products S·T and U·V. The product S·T appears in both results. It is formed once, stored in a temporary register and reused. The block has a single multiplier and a single adder. A fixed three-step schedule shares these two units through operand multiplexers and an internal shared bus. A small sequencer drives the unit selects and the register load enables.

Operands enter through a valid/ready handshake. The block accepts one operand set when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` stays low from that edge until the evaluation has finished. While `in_ready` is low, `in_valid` and the operand pins have no effect, so a caller that holds `in_valid` high is back-pressured and is not lost. The results sit in registers. `done` pulses once when both results are final. The results then hold until the next accepted operand set changes them. With 8-bit operands, products are 16 bits and results are 17 bits, so no sum can overflow.

Top module: `sched_expr_top`

## Requirements
- R1: When `done` is high, `res_x` equals W + S·T for the operand set accepted by the most recent handshake.
- R2: When `done` is high, `res_y` equals S·T + U·V for that same operand set.
- R3: Results are 2·W_OP+1 bits wide (17 with the default of 8). For all-ones operands, `res_x` is 65280 and `res_y` is 130050, with no wrap.
- R4: `in_ready` is high only while the sequencer is idle. A handshake is `in_valid && in_ready` at a rising edge, and it captures all five operands. In the cycle that follows, `in_ready` is low.
- R5: `done` goes high exactly four rising edges after the handshake edge and stays high for exactly one cycle. `in_ready` returns high in the cycle after `done`.
- R6: While `in_ready` is low, `in_valid` and the operand inputs are ignored. The results equal the captured set even when those pins change, and no second evaluation starts.
- R7: `res_x` and `res_y` keep their values across idle cycles until a new handshake occurs.
- R8: While `rst_n` is low, `in_ready` is 1, `done` is 0, and `res_x` and `res_y` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block idle and able to accept operands |
| op_w | input | W_OP | Addend of X |
| op_s | input | W_OP | First factor of the shared product |
| op_t | input | W_OP | Second factor of the shared product |
| op_u | input | W_OP | First factor of the second product |
| op_v | input | W_OP | Second factor of the second product |
| done | output | 1 | One-cycle pulse when both results are final |
| res_x | output | 2·W_OP+1 | Result W + S·T |
| res_y | output | 2·W_OP+1 | Result S·T + U·V |

## Verification
The checker takes its own copy of the operands at each handshake and compares the results against that copy when `done` pulses. It therefore depends only on reset being held low across at least one clock edge and on the handshake being the sole way operands enter. The stimulus keeps `in_valid` high with different operand values during every busy cycle, so a design that resampled its operands or restarted would be caught. It drops `in_valid` before the sequencer returns to idle, so the hold check sees one idle cycle with no handshake.

// File: rtl/sx_pkg.sv
package sx_pkg;

  typedef enum logic [2:0] {
    SX_IDLE = 3'd0,
    SX_MUL1 = 3'd1,
    SX_MUL2 = 3'd2,
    SX_ADD2 = 3'd3,
    SX_FIN  = 3'd4
  } sx_state_e;

  // Per-cycle controls issued by the sequencer
  typedef struct packed {
    logic cap_ops;   // latch operand set
    logic mul_uv;    // multiplier picks U,V (else S,T)
    logic ld_tmp;    // store shared product
    logic ld_p2;     // store second product
    logic bus_p2;    // shared bus carries second product (else shared product)
    logic add_tail;  // adder port A takes shared product (else W)
    logic ld_x;
    logic ld_y;
  } sx_ctrl_t;

endpackage

// File: rtl/sx_ctrl.sv
module sx_ctrl
  import sx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  output logic     done,
  output sx_ctrl_t ctl
);

  sx_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      SX_IDLE: if (in_valid) state_nx = SX_MUL1;
      SX_MUL1: state_nx = SX_MUL2;
      SX_MUL2: state_nx = SX_ADD2;
      SX_ADD2: state_nx = SX_FIN;
      SX_FIN:  state_nx = SX_IDLE;
      default: state_nx = SX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SX_IDLE;
    else        state <= state_nx;
  end

  always_comb begin
    ctl          = '0;
    ctl.cap_ops  = (state == SX_IDLE) && in_valid;
    ctl.ld_tmp   = (state == SX_MUL1);
    ctl.mul_uv   = (state == SX_MUL2);
    ctl.ld_p2    = (state == SX_MUL2);
    ctl.ld_x     = (state == SX_MUL2);
    ctl.bus_p2   = (state == SX_ADD2);
    ctl.add_tail = (state == SX_ADD2);
    ctl.ld_y     = (state == SX_ADD2);
  end

  assign in_ready = (state == SX_IDLE);
  assign done     = (state == SX_FIN);

endmodule

// File: rtl/sx_mul_unit.sv
module sx_mul_unit #(
  parameter int W_OP = 8,
  localparam int W_P = 2 * W_OP
) (
  input  logic [W_OP-1:0] a_st,
  input  logic [W_OP-1:0] b_st,
  input  logic [W_OP-1:0] a_uv,
  input  logic [W_OP-1:0] b_uv,
  input  logic            sel_uv,
  output logic [W_P-1:0]  prod
);

  logic [W_OP-1:0] fa, fb;

  assign fa   = sel_uv ? a_uv : a_st;
  assign fb   = sel_uv ? b_uv : b_st;
  assign prod = W_P'(fa) * W_P'(fb);

endmodule

// File: rtl/sx_add_unit.sv
module sx_add_unit #(
  parameter int W_OP = 8,
  localparam int W_P = 2 * W_OP,
  localparam int W_R = W_P + 1
) (
  input  logic [W_OP-1:0] addend_w,
  input  logic [W_P-1:0]  shared_p,
  input  logic [W_P-1:0]  bus,
  input  logic            sel_tail,
  output logic [W_R-1:0]  sum
);

  logic [W_P-1:0] port_a;

  assign port_a = sel_tail ? shared_p : W_P'(addend_w);
  assign sum    = W_R'(port_a) + W_R'(bus);

endmodule

// File: rtl/sched_expr_top.sv
module sched_expr_top
  import sx_pkg::*;
#(
  parameter int W_OP = 8,
  localparam int W_P = 2 * W_OP,
  localparam int W_R = W_P + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W_OP-1:0] op_w,
  input  logic [W_OP-1:0] op_s,
  input  logic [W_OP-1:0] op_t,
  input  logic [W_OP-1:0] op_u,
  input  logic [W_OP-1:0] op_v,
  output logic            done,
  output logic [W_R-1:0]  res_x,
  output logic [W_R-1:0]  res_y
);

  sx_ctrl_t ctl;

  logic [W_OP-1:0] rw, rs, rt, ru, rv;
  logic [W_P-1:0]  tmp_st, reg_p2, mul_out, shared_bus;
  logic [W_R-1:0]  add_out;

  sx_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .done     (done),
    .ctl      (ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw <= '0; rs <= '0; rt <= '0; ru <= '0; rv <= '0;
    end else if (ctl.cap_ops) begin
      rw <= op_w; rs <= op_s; rt <= op_t; ru <= op_u; rv <= op_v;
    end
  end

  sx_mul_unit #(.W_OP(W_OP)) u_mul (
    .a_st   (rs),
    .b_st   (rt),
    .a_uv   (ru),
    .b_uv   (rv),
    .sel_uv (ctl.mul_uv),
    .prod   (mul_out)
  );

  // Shared bus: stored shared product in step 2, second product in step 3
  assign shared_bus = ctl.bus_p2 ? reg_p2 : tmp_st;

  sx_add_unit #(.W_OP(W_OP)) u_add (
    .addend_w (rw),
    .shared_p (tmp_st),
    .bus      (shared_bus),
    .sel_tail (ctl.add_tail),
    .sum      (add_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_st <= '0;
      reg_p2 <= '0;
      res_x  <= '0;
      res_y  <= '0;
    end else begin
      if (ctl.ld_tmp) tmp_st <= mul_out;
      if (ctl.ld_p2)  reg_p2 <= mul_out;
      if (ctl.ld_x)   res_x  <= add_out;
      if (ctl.ld_y)   res_y  <= add_out;
    end
  end

endmodule

// File: rtl/sched_expr_chk.sv
module sched_expr_chk #(
  parameter int W_OP = 8,
  localparam int W_P = 2 * W_OP,
  localparam int W_R = W_P + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [W_OP-1:0] op_w,
  input logic [W_OP-1:0] op_s,
  input logic [W_OP-1:0] op_t,
  input logic [W_OP-1:0] op_u,
  input logic [W_OP-1:0] op_v,
  input logic            done,
  input logic [W_R-1:0]  res_x,
  input logic [W_R-1:0]  res_y
);

  logic            hs;
  logic [W_OP-1:0] cw, cs, ct, cu, cv;
  logic [W_R-1:0]  exp_x, exp_y;

  assign hs = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw <= '0; cs <= '0; ct <= '0; cu <= '0; cv <= '0;
    end else if (hs) begin
      cw <= op_w; cs <= op_s; ct <= op_t; cu <= op_u; cv <= op_v;
    end
  end

  assign exp_x = W_R'(cw) + W_R'(cs) * W_R'(ct);
  assign exp_y = W_R'(cs) * W_R'(ct) + W_R'(cu) * W_R'(cv);

  assert_x_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_x == exp_x);

  assert_y_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_y == exp_y);

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> !in_ready);

  assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> ##4 done);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && in_ready));

  assert_no_ready_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(res_x) && $stable(res_y)));

endmodule

bind sched_expr_top sched_expr_chk #(.W_OP(W_OP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .op_w     (op_w),
  .op_s     (op_s),
  .op_t     (op_t),
  .op_u     (op_u),
  .op_v     (op_v),
  .done     (done),
  .res_x    (res_x),
  .res_y    (res_y)
);

// File: tb/tb_sched_expr_top.sv
module tb_sched_expr_top;

  localparam int W_OP = 8;
  localparam int W_R  = 2 * W_OP + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready, done;
  logic [W_OP-1:0] op_w = '0, op_s = '0, op_t = '0, op_u = '0, op_v = '0;
  logic [W_R-1:0]  res_x, res_y;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sched_expr_top #(.W_OP(W_OP)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_w(op_w), .op_s(op_s), .op_t(op_t), .op_u(op_u), .op_v(op_v),
    .done(done), .res_x(res_x), .res_y(res_y)
  );

  task automatic chk(input string req, input longint act, input longint expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // One full evaluation; garbage is offered on every busy cycle (R6)
  task automatic run_set(input int w, input int s, input int t, input int u, input int v);
    longint ex = longint'(w) + longint'(s) * t;
    longint ey = longint'(s) * t + longint'(u) * v;
    op_w = W_OP'(w); op_s = W_OP'(s); op_t = W_OP'(t); op_u = W_OP'(u); op_v = W_OP'(v);
    in_valid = 1'b1;
    chk("R4 ready before accept", in_ready, 1);
    @(posedge clk); @(negedge clk);
    chk("R4 busy after accept", in_ready, 0);
    op_w = ~op_w; op_s = ~op_s; op_t = op_t + 8'd3; op_u = ~op_u; op_v = op_v ^ 8'h5a;
    @(posedge clk); @(negedge clk);
    chk("R5 no early done", done, 0);
    @(posedge clk); @(negedge clk);
    chk("R5 no early done", done, 0);
    chk("R6 still busy", in_ready, 0);
    @(posedge clk); @(negedge clk);
    chk("R5 done at fourth edge", done, 1);
    chk("R1 x value", res_x, ex);
    chk("R2 y value", res_y, ey);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R5 done one cycle", done, 0);
    chk("R5 ready after done", in_ready, 1);
    @(posedge clk); @(negedge clk);
    chk("R7 x held", res_x, ex);
    chk("R7 y held", res_y, ey);
    chk("R6 no second run", in_ready, 1);
  endtask

  initial begin
    int vals[7] = '{0, 1, 2, 127, 128, 254, 255};
    @(negedge clk);
    chk("R8 reset ready", in_ready, 1);
    chk("R8 reset done", done, 0);
    chk("R8 reset x", res_x, 0);
    chk("R8 reset y", res_y, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 extremes
    run_set(255, 255, 255, 255, 255);
    chk("R3 x max", res_x, 65280);
    chk("R3 y max", res_y, 130050);
    run_set(0, 0, 0, 0, 0);
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        for (int c = 0; c < 7; c++)
          for (int d = 0; d < 7; d++)
            for (int e = 0; e < 7; e++)
              run_set(vals[a], vals[b], vals[c], vals[d], vals[e]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule